// File: doc/BRIEF.md
# Five-Channel Output Compare Timer with Software Force

This block runs a free-running 16-bit up-counter that advances by one on every cycle where the `tick` input is high. The counter wraps from 0xFFFF to 0x0000. Five compare channels watch it. Each channel holds a 16-bit compare value. When a tick moves the counter onto that value, the channel applies its programmed action to its output pin and sets its status flag.

Software can also make selected channels act early by writing to a force register. A forced channel applies the same pin action on the next tick and leaves its flag untouched. This lets a pin be driven to a known level without a real match.

All state is reached over a byte-wide register bus with separate write and read strobes. Reads are registered and return data one cycle after the read strobe. A 16-bit compare value is written as a high byte followed by a low byte. Between those two writes the channel ignores matches, so the counter never sees a half-updated value.

Top module: `ocmp_unit`

## Requirements
- R1: After a synchronous reset:
  - every compare register reads 0xFFFF;
  - the counter reads 0x0000;
  - all pins and flags are 0;
  - all action selectors are 00.
- R2: The counter advances by one on each clock edge where `tick` is high and holds otherwise. It wraps from 0xFFFF to 0x0000. Its high byte reads at address 0xE and its low byte at address 0xF.
- R3: Channel n (1..5) has its compare high byte at address 2(n-1) and its low byte at address 2(n-1)+1. Read data appears on `rdata` in the cycle after `rd_en`.
- R4: A match happens on a tick edge where the incremented counter value equals the channel's compare value. On that same edge the channel applies its pin action and sets its flag.
- R5: Each channel has a 2-bit action code: 00 leaves the pin unchanged, 01 toggles it, 10 drives it low, 11 drives it high.
  - Channels 1..4 sit in the byte at address 0xB, channel k+1 in bits [2k+1:2k].
  - Channel 5 sits in bits [1:0] of address 0xC.
- R6: Writing the force register at address 0xA marks channels as pending: bit 7 is channel 1 and bit 3 is channel 5.
  - A pending force applies its action at the next tick edge after the write; a write made in the same cycle as a tick waits for the following tick.
  - Pending forces are cleared once applied.
- R7: A forced action never sets the channel's flag.
- R8: The force register always reads as 0x00, whatever was written, including bits 2..0.
- R9: When a force and a match fall on the same tick, the action is applied once and the flag is set. When a force is followed by a match on the next tick, a toggling pin toggles twice and returns to its old level.
- R10: After a compare high-byte write, the channel takes no match until its low byte is written.
- R11: The flags read at address 0xD, with bit 7 for channel 1 down to bit 3 for channel 5; bits 2..0 read 0.
  - Writing 1 to a flag bit clears that flag; bits written as 0 keep their flags.
  - `oc_flag` shows the flags directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter advance enable, one cycle per count |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| oc_pin | output | 5 | Compare output pins, bit 0 is channel 1 |
| oc_flag | output | 5 | Compare status flags, bit 0 is channel 1 |

## Verification
A vector table tries each action code on several channels at different match distances. Each vector checks that the pin and flag stay quiet until the matching tick and change exactly on it, which separates an early or late match from a correct one.

Directed sequences cover the force path:
- a force written with no tick, and a force written in the same cycle as a tick, which separates a deferred force from an immediate one;
- a force followed by a match, which shows the double toggle;
- a force and a match on the same tick, which shows the single application.

Further directed sequences cover:
- matches blocked while only the high byte of a compare value is new;
- flag write-1-to-clear that leaves other flags alone;
- the counter wrap through 0xFFFF.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } oc_act_e;

  // Pin level after one compare event under the given action
  function automatic logic next_pin(oc_act_e act, logic cur);
    case (act)
      ACT_TOGGLE: next_pin = ~cur;
      ACT_LOW:    next_pin = 1'b0;
      ACT_HIGH:   next_pin = 1'b1;
      default:    next_pin = cur;
    endcase
  endfunction

endpackage

// File: rtl/ocmp_counter.sv
module ocmp_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);

  assign cnt_nxt = cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt_nxt;
  end

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  a_r2_wraps_to_zero: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == {CW{1'b1}}) |=> cnt == '0);

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
  import ocmp_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [2*BW-1:0] cnt_nxt,
  input  logic            wr_hi,
  input  logic            wr_lo,
  input  logic [BW-1:0]   wdata,
  input  oc_act_e         act,
  input  logic            frc,
  input  logic            flag_clr,
  output logic [2*BW-1:0] cmp_q,
  output logic            pin,
  output logic            flag
);

  localparam int CW = 2 * BW;

  logic blk_q;   // high byte written, low byte still pending
  logic hit;
  logic evt;

  assign hit = tick && !blk_q && (cnt_nxt == cmp_q);
  assign evt = hit || (tick && frc);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '1;
      blk_q <= 1'b0;
      pin   <= 1'b0;
      flag  <= 1'b0;
    end else begin
      if (wr_hi) begin
        cmp_q[CW-1:BW] <= wdata;
        blk_q          <= 1'b1;
      end
      if (wr_lo) begin
        cmp_q[BW-1:0] <= wdata;
        blk_q         <= 1'b0;
      end
      if (evt)           pin  <= next_pin(act, pin);
      if (hit)           flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  // R7: a force with no coincident match never raises the flag
  a_r7_force_no_flag: assert property (@(posedge clk) disable iff (rst)
    (tick && frc && (cnt_nxt != cmp_q) && !flag) |=> !flag);

  // R10: a half-written compare value never raises the flag
  a_r10_blocked_no_flag: assert property (@(posedge clk) disable iff (rst)
    (tick && blk_q && !flag) |=> !flag);

  // R4: pin changes only on tick edges
  a_r4_pin_quiet_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pin));

endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
  import ocmp_pkg::*;
#(
  parameter int NCH = 5,
  parameter int BW  = 8,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [BW-1:0]  wdata,
  output logic [BW-1:0]  rdata,
  output logic [NCH-1:0] oc_pin,
  output logic [NCH-1:0] oc_flag
);

  localparam int CW   = 2 * BW;
  localparam int APB  = BW / 2;              // action fields per byte
  localparam int NACT = (NCH + APB - 1) / APB;
  localparam logic [AW-1:0] A_FRC  = AW'(2 * NCH);
  localparam logic [AW-1:0] A_ACT0 = AW'(2 * NCH + 1);
  localparam logic [AW-1:0] A_FLG  = AW'(2 * NCH + 1 + NACT);
  localparam logic [AW-1:0] A_CNTH = AW'(2 * NCH + 2 + NACT);
  localparam logic [AW-1:0] A_CNTL = AW'(2 * NCH + 3 + NACT);

  logic [CW-1:0]    cnt;
  logic [CW-1:0]    cnt_nxt;
  logic [CW-1:0]    cmp_v [NCH];
  logic [2*NCH-1:0] act_bus;
  logic [NCH-1:0]   frc_q;
  logic [NCH-1:0]   frc_set;
  logic             frc_wr;
  logic [BW-1:0]    rd_mux;

  ocmp_counter #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt)
  );

  assign frc_wr = wr_en && (addr == A_FRC);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [AW-1:0] A_HI  = AW'(2 * g);
    localparam logic [AW-1:0] A_LO  = AW'(2 * g + 1);
    localparam logic [AW-1:0] A_ACT = AW'(2 * NCH + 1 + g / APB);
    localparam int            FOFS  = 2 * (g % APB);
    oc_act_e act_q;
    logic    clr;

    always_ff @(posedge clk) begin
      if (rst)
        act_q <= ACT_NONE;
      else if (wr_en && addr == A_ACT)
        act_q <= oc_act_e'(wdata[FOFS +: 2]);
    end

    assign act_bus[2*g +: 2] = act_q;
    assign frc_set[g]        = frc_wr && wdata[BW-1-g];
    assign clr               = wr_en && (addr == A_FLG) && wdata[BW-1-g];

    ocmp_channel #(.BW(BW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .cnt_nxt  (cnt_nxt),
      .wr_hi    (wr_en && addr == A_HI),
      .wr_lo    (wr_en && addr == A_LO),
      .wdata    (wdata),
      .act      (act_q),
      .frc      (frc_q[g]),
      .flag_clr (clr),
      .cmp_q    (cmp_v[g]),
      .pin      (oc_pin[g]),
      .flag     (oc_flag[g])
    );
  end

  // Pending forces: consumed by a tick, new writes wait for the next one
  always_ff @(posedge clk) begin
    if (rst) frc_q <= '0;
    else     frc_q <= (tick ? '0 : frc_q) | frc_set;
  end

  always_comb begin
    rd_mux = '0;
    for (int n = 0; n < NCH; n++) begin
      if (addr == AW'(2 * n))     rd_mux = cmp_v[n][CW-1:BW];
      if (addr == AW'(2 * n + 1)) rd_mux = cmp_v[n][BW-1:0];
      if (addr == AW'(2 * NCH + 1 + n / APB))
        rd_mux[2*(n%APB) +: 2] = act_bus[2*n +: 2];
      if (addr == A_FLG) rd_mux[BW-1-n] = oc_flag[n];
    end
    if (addr == A_CNTH) rd_mux = cnt[CW-1:BW];
    if (addr == A_CNTL) rd_mux = cnt[BW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  a_r8_force_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_FRC) |=> rdata == '0);

  a_r6_pending_cleared_by_tick: assert property (@(posedge clk) disable iff (rst)
    (tick && !frc_wr) |=> frc_q == '0);

  a_r11_flag_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_FLG) |=> rdata[BW-NCH-1:0] == '0);

endmodule

// File: tb/sim_ocmp_unit.sv
`timescale 1ns/1ps
module sim_ocmp_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [4:0] oc_pin, oc_flag;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [15:0] mcnt = '0;
  logic [4:0]  mpin = '0;
  logic [1:0]  mact [5] = '{default: 2'b00};

  always #5 clk = ~clk;

  ocmp_unit u0 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .oc_pin(oc_pin), .oc_flag(oc_flag)
  );

  // {channel 1..5, action code, ticks to match}
  localparam logic [12:0] VEC [10] = '{
    {3'd1, 2'd3, 8'd3}, {3'd2, 2'd1, 8'd1}, {3'd3, 2'd3, 8'd5}, {3'd3, 2'd2, 8'd2},
    {3'd4, 2'd1, 8'd4}, {3'd5, 2'd3, 8'd2}, {3'd5, 2'd1, 8'd1}, {3'd2, 2'd0, 8'd3},
    {3'd1, 2'd1, 8'd6}, {3'd4, 2'd3, 8'd1}
  };

  function automatic logic nxt(logic [1:0] a, logic p);
    case (a)
      2'd1: nxt = ~p;
      2'd2: nxt = 1'b0;
      2'd3: nxt = 1'b1;
      default: nxt = p;
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic tk();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    mcnt++;
  endtask

  task automatic set_act(int ch, logic [1:0] a);
    int b;
    logic [7:0] d;
    mact[ch-1] = a;
    b = (ch - 1) / 4;
    d = '0;
    for (int k = 0; k < 4; k++)
      if (4*b + k < 5) d[2*k +: 2] = mact[4*b + k];
    wr(4'd11 + 4'(b), d);
  endtask

  task automatic set_cmp(int ch, logic [15:0] v);
    wr(4'(2*(ch-1)), v[15:8]);
    wr(4'(2*(ch-1)+1), v[7:0]);
  endtask

  task automatic clr_flag(int ch);
    wr(4'd13, 8'h80 >> (ch - 1));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    logic [15:0] t;
    int ch;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pins", 16'(oc_pin), 16'h0);
    chk("R1 flags", 16'(oc_flag), 16'h0);
    rd(4'd0, d); rd(4'd9, d2);
    chk("R1 compare bytes", {d, d2}, 16'hFFFF);
    rd(4'd14, d); rd(4'd15, d2);
    chk("R1 counter", {d, d2}, 16'h0);
    rd(4'd11, d);
    chk("R1 actions", 16'(d), 16'h0);

    // R4 R5 vector table
    for (int i = 0; i < 10; i++) begin
      logic ok;
      ch = int'(VEC[i][12:10]);
      set_act(ch, VEC[i][9:8]);
      t = mcnt + 16'(VEC[i][7:0]);
      set_cmp(ch, t);
      clr_flag(ch);
      ok = 1;
      for (int k = 1; k < int'(VEC[i][7:0]); k++) begin
        tk();
        if (oc_pin[ch-1] !== mpin[ch-1] || oc_flag[ch-1] !== 1'b0) ok = 0;
      end
      chk("R4 quiet before match", 16'(ok), 16'h1);
      tk();
      mpin[ch-1] = nxt(mact[ch-1], mpin[ch-1]);
      chk("R4 R5 pin and flag at match", {oc_pin[ch-1], oc_flag[ch-1]}, {mpin[ch-1], 1'b1});
    end

    // R3 read back, R2 counter value and hold
    set_cmp(2, 16'h1234);
    rd(4'd2, d); rd(4'd3, d2);
    chk("R3 compare readback", {d, d2}, 16'h1234);
    rd(4'd14, d); rd(4'd15, d2);
    chk("R2 counter count", {d, d2}, mcnt);
    repeat (4) @(negedge clk);
    rd(4'd15, d2);
    chk("R2 counter holds", 16'(d2), 16'(mcnt[7:0]));

    // R6 R7 R8 force without tick, then apply
    set_act(3, 2'd1);
    set_cmp(3, mcnt + 16'd300);
    clr_flag(3);
    wr(4'd10, 8'h07);
    wr(4'd10, 8'h20);
    rd(4'd10, d);
    chk("R8 force reads zero", 16'(d), 16'h0);
    repeat (3) @(negedge clk);
    chk("R6 no action before tick", 16'(oc_pin[2]), 16'(mpin[2]));
    tk(); mpin[2] = ~mpin[2];
    chk("R6 force applied at tick", 16'(oc_pin[2]), 16'(mpin[2]));
    chk("R7 forced flag stays clear", 16'(oc_flag[2]), 16'h0);
    tk();
    chk("R6 pending cleared", 16'(oc_pin[2]), 16'(mpin[2]));

    // R6 force written in a tick cycle waits for the next tick
    @(negedge clk); wr_en = 1; addr = 4'd10; wdata = 8'h20; tick = 1;
    @(negedge clk); wr_en = 0; tick = 0; mcnt++;
    chk("R6 same-cycle write deferred", 16'(oc_pin[2]), 16'(mpin[2]));
    tk(); mpin[2] = ~mpin[2];
    chk("R6 deferred force applied", 16'(oc_pin[2]), 16'(mpin[2]));

    // R9 force then match: double toggle
    set_act(4, 2'd1);
    set_cmp(4, mcnt + 16'd2);
    clr_flag(4);
    t = 16'(mpin[3]);
    wr(4'd10, 8'h10);
    tk();
    chk("R9 force toggles", {oc_pin[3], oc_flag[3]}, {~mpin[3], 1'b0});
    tk();
    chk("R9 match toggles back", {oc_pin[3], oc_flag[3]}, {t[0], 1'b1});
    // R9 force and match on the same tick: applied once
    set_cmp(4, mcnt + 16'd1);
    clr_flag(4);
    wr(4'd10, 8'h10);
    tk(); mpin[3] = ~mpin[3];
    chk("R9 coincident applied once", {oc_pin[3], oc_flag[3]}, {mpin[3], 1'b1});

    // R10 high byte write blocks matches until low byte
    set_act(5, 2'd1);
    t = mcnt + 16'd1;
    wr(4'd9, t[7:0]);
    wr(4'd8, t[15:8]);
    clr_flag(5);
    tk();
    chk("R10 blocked match", {oc_pin[4], oc_flag[4]}, {mpin[4], 1'b0});
    t = mcnt + 16'd1;
    wr(4'd9, t[7:0]);
    tk(); mpin[4] = ~mpin[4];
    chk("R10 match after low byte", {oc_pin[4], oc_flag[4]}, {mpin[4], 1'b1});

    // R11 flag clear and read
    wr(4'd13, 8'hF8);
    chk("R11 clear all", 16'(oc_flag), 16'h0);
    set_cmp(2, mcnt + 16'd1);
    tk(); mpin[1] = nxt(mact[1], mpin[1]);
    rd(4'd13, d);
    chk("R11 flag read", 16'(d), 16'h40);
    wr(4'd13, 8'h87);
    rd(4'd13, d);
    chk("R11 other flag kept", 16'(d), 16'h40);
    wr(4'd13, 8'h40);
    chk("R11 flag cleared", 16'(oc_flag), 16'h0);

    // R2 wrap through 0xFFFF
    set_act(1, 2'd1);
    set_cmp(1, 16'h0000);
    clr_flag(1);
    t = 16'hFFFF - mcnt;
    @(negedge clk); tick = 1;
    repeat (int'(t)) @(negedge clk);
    tick = 0; mcnt = 16'hFFFF;
    rd(4'd14, d); rd(4'd15, d2);
    chk("R2 counter at top", {d, d2}, 16'hFFFF);
    tk(); mpin[0] = ~mpin[0];
    chk("R2 wrap match", {oc_pin[0], oc_flag[0]}, {mpin[0], 1'b1});
    rd(4'd14, d); rd(4'd15, d2);
    chk("R2 counter wrapped", {d, d2}, 16'h0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule